// File: doc/BRIEF.md
# Raster-Locked Frame Store Arbiter

This block decides who may use a single SDRAM frame store that two clients share. One client refreshes an LCD and needs a whole line of pixels fetched before that line is scanned. The other client is a renderer that fills the hidden frame area. The arbiter follows the display raster through its horizontal and vertical blanking inputs. Display line fetches are issued as fixed-length burst reads and may run at any time. Render writes are accepted only while blanking is active, and only while the remaining blanking time still covers a complete write burst.

The arbiter keeps two frame base addresses. Reads go to the front frame and writes go to the back frame. When the renderer signals that the back frame is finished, the two frames exchange roles at the next start of vertical blanking. Until then the current front frame stays on screen. Every pixel address is formed as base + line × line length + column.

On the memory side the block drives a request/acknowledge burst command port. A command stays asserted, unchanged, until it is acknowledged. The arbiter then waits for the controller's burst-complete pulse before it issues anything else. On the renderer side, a hold output tells the source to keep its request and data.

Top module: `fba_arbiter`

## Requirements
- R1: While reset is held and directly after it, `mem_req` is 0, `front_sel` is 0 (frame A is on display) and `wr_hold` is 1.
- R2: A one-cycle `disp_fetch` pulse with line L produces LINE_PIX/BURST_LEN read commands (`mem_we`=0). Their addresses are front base + L·LINE_PIX + k·BURST_LEN for k = 0, 1, 2, … in ascending order.
- R3: While `hblank` and `vblank` are both 0, no write command is issued and `wr_hold` is 1.
- R4: During blanking, when the arbiter is idle with no display fetch pending and at least WR_COST window cycles remain, `wr_hold` is 0. A request (`wr_req`=1) in that cycle is accepted and issued as a write (`mem_we`=1) at back base + `wr_line`·LINE_PIX + `wr_col`.
- R5: The window counter loads HBLANK_CYC on a rising `hblank` and VBLANK_CYC on a rising `vblank`, then counts down by one each cycle. No new write is accepted once fewer than WR_COST cycles remain, and `wr_hold` stays 1.
- R6: An accepted write is issued to the memory port even if blanking ends before it is acknowledged. The arbiter then returns to idle after `mem_done`.
- R7: While a display fetch is pending, no new write is accepted. Every burst of the line is issued before the next write, so at most the one write already in flight comes ahead of them.
- R8: Once `mem_req` is 1, it stays 1 with `mem_addr` and `mem_we` unchanged until `mem_ack`.
- R9: `front_sel` toggles only on a rising `vblank`, and only if `back_done` has pulsed since the last swap. A rising `vblank` without it leaves `front_sel` unchanged.
- R10: After a swap, reads use the new front base (frame B when `front_sel`=1) and writes use the other base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-side clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank | input | 1 | Horizontal blanking level from the raster timing |
| vblank | input | 1 | Vertical blanking level from the raster timing |
| disp_fetch | input | 1 | One-cycle pulse: fetch a display line |
| disp_line | input | LINE_W | Line to fetch, sampled with `disp_fetch` |
| back_done | input | 1 | One-cycle pulse: back frame is complete |
| wr_req | input | 1 | Renderer offers one write burst |
| wr_line | input | LINE_W | Line of the offered write burst |
| wr_col | input | COL_W | First column of the offered write burst |
| wr_hold | output | 1 | 1: the renderer must hold its request |
| mem_req | output | 1 | Burst command valid |
| mem_we | output | 1 | 1 write burst, 0 read burst |
| mem_addr | output | FBA_ADDR_W | Burst start address in pixels |
| mem_ack | input | 1 | Controller accepted the command |
| mem_done | input | 1 | Controller finished the burst |
| front_sel | output | 1 | 0: frame A displayed, 1: frame B displayed |

## Verification
The bench targets the edges of the blanking window. A write offered near the end of a horizontal blank must stay held; a design that compares against the raw window rather than the burst cost would start a write that spills into active video. A write accepted just before blanking ends must still reach the memory port; a design that cancels it on the blank edge would drop a pixel burst or leave the renderer out of step. A display fetch arriving while writes are streaming in vertical blanking must overtake every later write; a design that does not check pending reads would starve the line buffer. Swap tests pair vertical blanks with and without a completion pulse, and check the read and write bases on both sides of each swap; a design that swaps unconditionally would show half-drawn frames.

// File: rtl/fba_pkg.sv
package fba_pkg;

    localparam int unsigned FBA_ADDR_W = 24;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_RD_REQ,
        ARB_RD_WAIT,
        ARB_WR_REQ,
        ARB_WR_WAIT
    } arb_state_t;

    typedef struct packed {
        logic                  we;
        logic [FBA_ADDR_W-1:0] addr;
    } mem_cmd_t;

    function automatic logic [FBA_ADDR_W-1:0] pix_addr(
        input logic [FBA_ADDR_W-1:0] base,
        input logic [31:0]           line,
        input logic [31:0]           col,
        input logic [31:0]           line_pix
    );
        logic [31:0] ofs;
        ofs = line * line_pix + col;
        return base + ofs[FBA_ADDR_W-1:0];
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fba_window.sv
module fba_window #(
    parameter int unsigned HBLANK_CYC = 410,
    parameter int unsigned VBLANK_CYC = 52500,
    parameter int unsigned CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hblank,
    input  logic             vblank,
    output logic             blank,
    output logic [CNT_W-1:0] win_cnt
);
    logic hb_q, vb_q;

    assign blank = hblank | vblank;

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_q    <= 1'b0;
            vb_q    <= 1'b0;
            win_cnt <= '0;
        end else begin
            hb_q <= hblank;
            vb_q <= vblank;
            if (vblank && !vb_q)
                win_cnt <= CNT_W'(VBLANK_CYC);
            else if (hblank && !hb_q && !vblank)
                win_cnt <= CNT_W'(HBLANK_CYC);
            else if (win_cnt != '0)
                win_cnt <= win_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fba_swap.sv
module fba_swap (
    input  logic clk,
    input  logic rst,
    input  logic vblank,
    input  logic back_done,
    output logic front_sel
);
    logic vb_q, ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q      <= 1'b0;
            ready     <= 1'b0;
            front_sel <= 1'b0;
        end else begin
            vb_q <= vblank;
            if (vblank && !vb_q && ready) begin
                front_sel <= ~front_sel;
                ready     <= back_done;
            end else if (back_done) begin
                ready <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fba_rdseq.sv
module fba_rdseq #(
    parameter int unsigned LINE_PIX  = 480,
    parameter int unsigned BURST_LEN = 8,
    parameter int unsigned LINE_W    = 9,
    parameter int unsigned COL_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic [LINE_W-1:0] fetch_line,
    input  logic              adv,
    output logic              pending,
    output logic [LINE_W-1:0] line,
    output logic [COL_W-1:0]  col
);
    logic last_burst;

    assign last_burst = (32'(col) + BURST_LEN) >= LINE_PIX;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            line    <= '0;
            col     <= '0;
        end else if (fetch) begin
            pending <= 1'b1;
            line    <= fetch_line;
            col     <= '0;
        end else if (adv && pending) begin
            if (last_burst)
                pending <= 1'b0;
            else
                col <= col + COL_W'(BURST_LEN);
        end
    end
endmodule

// File: rtl/fba_arbiter.sv
module fba_arbiter
    import fba_pkg::*;
#(
    parameter int unsigned          LINE_PIX    = 480,
    parameter int unsigned          BURST_LEN   = 8,
    parameter int unsigned          LINE_W      = 9,
    parameter int unsigned          COL_W       = 9,
    parameter int unsigned          HBLANK_CYC  = 410,
    parameter int unsigned          VBLANK_CYC  = 52500,
    parameter int unsigned          WR_OVH      = 6,
    parameter logic [FBA_ADDR_W-1:0] FRAME0_BASE = 24'h000000,
    parameter logic [FBA_ADDR_W-1:0] FRAME1_BASE = 24'h040000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hblank,
    input  logic                  vblank,
    input  logic                  disp_fetch,
    input  logic [LINE_W-1:0]     disp_line,
    input  logic                  back_done,
    input  logic                  wr_req,
    input  logic [LINE_W-1:0]     wr_line,
    input  logic [COL_W-1:0]      wr_col,
    output logic                  wr_hold,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [FBA_ADDR_W-1:0] mem_addr,
    input  logic                  mem_ack,
    input  logic                  mem_done,
    output logic                  front_sel
);
    localparam int unsigned WR_COST = BURST_LEN + WR_OVH;
    localparam int unsigned CNT_W   = $clog2(max_u(HBLANK_CYC, VBLANK_CYC) + 1);

    arb_state_t          state;
    mem_cmd_t            cmd;
    logic                blank;
    logic [CNT_W-1:0]    win_cnt;
    logic                rd_pend, rd_adv, wr_ok;
    logic [LINE_W-1:0]   rd_line;
    logic [COL_W-1:0]    rd_col;
    logic [FBA_ADDR_W-1:0] front_base, back_base;

    fba_window #(.HBLANK_CYC(HBLANK_CYC), .VBLANK_CYC(VBLANK_CYC), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst(rst), .hblank(hblank), .vblank(vblank),
        .blank(blank), .win_cnt(win_cnt)
    );

    fba_swap u_swap (
        .clk(clk), .rst(rst), .vblank(vblank), .back_done(back_done),
        .front_sel(front_sel)
    );

    fba_rdseq #(.LINE_PIX(LINE_PIX), .BURST_LEN(BURST_LEN), .LINE_W(LINE_W), .COL_W(COL_W)) u_rd (
        .clk(clk), .rst(rst), .fetch(disp_fetch), .fetch_line(disp_line),
        .adv(rd_adv), .pending(rd_pend), .line(rd_line), .col(rd_col)
    );

    assign front_base = front_sel ? FRAME1_BASE : FRAME0_BASE;
    assign back_base  = front_sel ? FRAME0_BASE : FRAME1_BASE;

    assign wr_ok   = blank && (state == ARB_IDLE) && !rd_pend && (32'(win_cnt) >= WR_COST);
    assign wr_hold = !wr_ok;
    assign rd_adv  = (state == ARB_RD_WAIT) && mem_done;

    assign mem_req  = (state == ARB_RD_REQ) || (state == ARB_WR_REQ);
    assign mem_we   = cmd.we;
    assign mem_addr = cmd.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ARB_IDLE;
            cmd   <= '0;
        end else begin
            unique case (state)
                ARB_IDLE: begin
                    if (rd_pend) begin
                        state    <= ARB_RD_REQ;
                        cmd.we   <= 1'b0;
                        cmd.addr <= pix_addr(front_base, 32'(rd_line), 32'(rd_col), LINE_PIX);
                    end else if (wr_req && wr_ok) begin
                        state    <= ARB_WR_REQ;
                        cmd.we   <= 1'b1;
                        cmd.addr <= pix_addr(back_base, 32'(wr_line), 32'(wr_col), LINE_PIX);
                    end
                end
                ARB_RD_REQ:  if (mem_ack)  state <= ARB_RD_WAIT;
                ARB_RD_WAIT: if (mem_done) state <= ARB_IDLE;
                ARB_WR_REQ:  if (mem_ack)  state <= ARB_WR_WAIT;
                ARB_WR_WAIT: if (mem_done) state <= ARB_IDLE;
                default:                   state <= ARB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fba_checker.sv
module fba_checker
    import fba_pkg::*;
#(
    parameter int unsigned WR_COST = 14,
    parameter int unsigned CNT_W   = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  hblank,
    input logic                  vblank,
    input logic                  mem_req,
    input logic                  mem_ack,
    input logic                  mem_we,
    input logic [FBA_ADDR_W-1:0] mem_addr,
    input logic                  wr_hold,
    input logic                  front_sel,
    input logic                  rd_pend,
    input logic [CNT_W-1:0]      win_cnt
);
    // R3
    no_active_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && mem_we |-> $past(hblank || vblank));

    // R3
    hold_in_active_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hold |-> (hblank || vblank));

    // R5
    window_fits_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && mem_we |-> (32'($past(win_cnt)) >= WR_COST));

    // R7
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && mem_we |-> !$past(rd_pend));

    // R8
    cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> wr_hold);

    // R9
    swap_in_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(front_sel) |-> $past(vblank));
endmodule

bind fba_arbiter fba_checker #(.WR_COST(WR_COST), .CNT_W(CNT_W)) u_fba_chk (
    .clk(clk), .rst(rst), .hblank(hblank), .vblank(vblank),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .wr_hold(wr_hold), .front_sel(front_sel), .rd_pend(rd_pend), .win_cnt(win_cnt)
);

// File: tb/test_fba_arbiter.sv
module test_fba_arbiter;
    import fba_pkg::*;

    localparam int unsigned LP  = 16;
    localparam int unsigned BL  = 4;
    localparam int unsigned HB  = 20;
    localparam int unsigned VB  = 60;
    localparam int unsigned OVH = 4;
    localparam logic [FBA_ADDR_W-1:0] F0 = 24'h000000;
    localparam logic [FBA_ADDR_W-1:0] F1 = 24'h001000;

    logic clk = 1'b0, rst = 1'b1;
    logic hblank = 0, vblank = 0, disp_fetch = 0, back_done = 0, wr_req = 0;
    logic [8:0] disp_line = '0, wr_line = '0, wr_col = '0;
    logic wr_hold, mem_req, mem_we, mem_ack = 0, mem_done = 0, front_sel;
    logic [FBA_ADDR_W-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    int log_n = 0;
    logic                  log_we   [0:255];
    logic [FBA_ADDR_W-1:0] log_addr [0:255];
    int busy = 0;

    always #4 clk = ~clk;

    fba_arbiter #(
        .LINE_PIX(LP), .BURST_LEN(BL), .LINE_W(9), .COL_W(9),
        .HBLANK_CYC(HB), .VBLANK_CYC(VB), .WR_OVH(OVH),
        .FRAME0_BASE(F0), .FRAME1_BASE(F1)
    ) i_fba_arbiter (
        .clk(clk), .rst(rst), .hblank(hblank), .vblank(vblank),
        .disp_fetch(disp_fetch), .disp_line(disp_line), .back_done(back_done),
        .wr_req(wr_req), .wr_line(wr_line), .wr_col(wr_col), .wr_hold(wr_hold),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_done(mem_done), .front_sel(front_sel)
    );

    // Memory controller model: ack one cycle, done BL cycles later.
    always @(negedge clk) begin
        mem_ack  = 1'b0;
        mem_done = 1'b0;
        if (busy > 0) begin
            busy = busy - 1;
            if (busy == 0) mem_done = 1'b1;
        end else if (mem_req && !rst) begin
            mem_ack = 1'b1;
            if (log_n < 256) begin
                log_we[log_n]   = mem_we;
                log_addr[log_n] = mem_addr;
            end
            log_n = log_n + 1;
            busy  = BL;
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_fetch(input int line);
        disp_line  = 9'(line);
        disp_fetch = 1'b1;
        @(negedge clk);
        disp_fetch = 1'b0;
    endtask

    task automatic t_reset;
        cycles(1);
        check(mem_req == 1'b0,   "R1 mem_req",   mem_req, 0);
        check(front_sel == 1'b0, "R1 front_sel", front_sel, 0);
        check(wr_hold == 1'b1,   "R1 wr_hold",   wr_hold, 1);
        rst = 1'b0;
        cycles(2);
        check(mem_req == 1'b0, "R1 idle after reset", mem_req, 0);
    endtask

    task automatic t_line_fetch;
        int n0;
        n0 = log_n;
        wr_req = 1'b1; wr_line = 9'd1; wr_col = 9'd0;
        pulse_fetch(3);
        cycles(3);
        check(wr_hold == 1'b1, "R3 hold in active", wr_hold, 1);
        cycles(50);
        wr_req = 1'b0;
        check(log_n - n0 == int'(LP / BL), "R2 burst count", log_n - n0, LP / BL);
        for (int k = 0; k < int'(LP / BL); k++) begin
            check(log_we[n0+k] == 1'b0, "R3 read only in active", log_we[n0+k], 0);
            check(log_addr[n0+k] == F0 + 24'(3*LP + k*BL), "R2 read addr",
                  log_addr[n0+k], F0 + 24'(3*LP + k*BL));
        end
    endtask

    task automatic t_hblank_write;
        int n0;
        n0 = log_n;
        hblank = 1'b1;
        cycles(3);
        wr_line = 9'd2; wr_col = 9'd4; wr_req = 1'b1;
        #1;
        check(wr_hold == 1'b0, "R4 hold released", wr_hold, 0);
        @(negedge clk);
        wr_req = 1'b0;
        cycles(20);
        hblank = 1'b0;
        cycles(2);
        check(log_n - n0 == 1, "R4 one write", log_n - n0, 1);
        check(log_we[n0] == 1'b1, "R4 write kind", log_we[n0], 1);
        check(log_addr[n0] == F1 + 24'(2*LP + 4), "R4 write addr", log_addr[n0], F1 + 24'(2*LP + 4));
    endtask

    task automatic t_window_end;
        int n0;
        n0 = log_n;
        hblank = 1'b1;
        cycles(16);
        wr_line = 9'd0; wr_col = 9'd0; wr_req = 1'b1;
        #1;
        check(wr_hold == 1'b1, "R5 hold near window end", wr_hold, 1);
        cycles(15);
        check(log_n == n0, "R5 no late write", log_n - n0, 0);
        check(wr_hold == 1'b1, "R5 hold after window", wr_hold, 1);
        wr_req = 1'b0;
        hblank = 1'b0;
        cycles(2);
    endtask

    task automatic t_finish_after_blank;
        int n0;
        n0 = log_n;
        hblank = 1'b1;
        cycles(3);
        wr_line = 9'd5; wr_col = 9'd8; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        hblank = 1'b0;
        cycles(12);
        check(log_n - n0 == 1, "R6 write completed", log_n - n0, 1);
        check(log_addr[n0] == F1 + 24'(5*LP + 8), "R6 write addr", log_addr[n0], F1 + 24'(5*LP + 8));
        check(mem_req == 1'b0, "R6 back to idle", mem_req, 0);
    endtask

    task automatic t_preempt;
        int n0, reads, writes;
        vblank = 1'b1;
        wr_line = 9'd1; wr_col = 9'd0; wr_req = 1'b1;
        cycles(4);
        n0 = log_n;
        pulse_fetch(6);
        cycles(55);
        wr_req = 1'b0;
        vblank = 1'b0;
        cycles(12);
        reads = 0; writes = 0;
        for (int i = n0; i < log_n && reads < int'(LP / BL); i++) begin
            if (log_we[i]) writes++;
            else reads++;
        end
        check(reads == int'(LP / BL), "R7 all reads issued", reads, LP / BL);
        check(writes <= 1, "R7 writes ahead of reads", writes, 1);
        check(front_sel == 1'b0, "R9 no swap without done", front_sel, 0);
    endtask

    task automatic t_swap;
        int n0;
        back_done = 1'b1;
        @(negedge clk);
        back_done = 1'b0;
        vblank = 1'b1;
        cycles(2);
        check(front_sel == 1'b1, "R9 swap on vblank", front_sel, 1);
        n0 = log_n;
        pulse_fetch(1);
        cycles(40);
        wr_line = 9'd0; wr_col = 9'd8; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        cycles(12);
        vblank = 1'b0;
        cycles(2);
        check(log_addr[n0] == F1 + 24'(LP), "R10 read from new front", log_addr[n0], F1 + 24'(LP));
        check(log_we[n0+4] == 1'b1 && log_addr[n0+4] == F0 + 24'd8, "R10 write to old front",
              log_addr[n0+4], F0 + 24'd8);
        vblank = 1'b1;
        cycles(3);
        vblank = 1'b0;
        cycles(2);
        check(front_sel == 1'b1, "R9 second vblank no done", front_sel, 1);
    endtask

    initial begin
        t_reset();
        t_line_fetch();
        t_hblank_write();
        t_window_end();
        t_finish_after_blank();
        t_preempt();
        t_swap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule